// File: doc/BRIEF.md
# Power-Up Reset and Port Option Loader

This block takes a small controller core from power-up, or from an external reset, to its first instruction fetch. It watches an active-low reset input and an active-low hold input. It counts instruction cycles while reset is low, and it rejects a low pulse that is too short. After a valid release it opens a fixed nine-instruction-cycle window. During that window all port pins are kept in the open-drain output type. Meanwhile the block reads the sixteen option bytes kept at the top of program memory, at 3FF0h through 3FFFh.

In the last cycle of the window, the collected option bits move into the live output-type register in a single step. At the same time the block pulses a program-counter clear, so the core starts at address zero. Once the core is running, pulling hold low parks it. From hold, the core can only come back through the full reset sequence: hold is raised first, then reset is pulsed.

Instruction cycles are marked by a one-clock strobe. Strobes must be at least two clocks apart. The program-memory read port is combinational: the address and read enable go out, and the data byte comes back in the same clock.

Top module: `boot_sequencer`

## Requirements
- R1: While `rstN` is low, `pinType` is all zeros (0 = open-drain, 1 = push-pull), whatever was latched before. `run` and `pcClr` are low from the first clock edge that samples `rstN` low.
- R2: A reset low time that spans fewer than 3 strobes (counted from the clock after `rstN` is first sampled low) is rejected. After release there are no reads and no `pcClr`, `run` stays low and `pinType` stays zero until a later valid reset.
- R3: After a valid release, `pcClr` is high for exactly one clock. That clock follows the edge that samples the 9th strobe after the release edge. There is one pulse per window.
- R4: During the window, `memRd` is high on each of the first 8 strobe clocks and on the clock right after each of them. The 16 reads present addresses 3FF0h, 3FF1h, … 3FFFh in ascending order.
- R5: `pinType` stays zero throughout the window. On the same edge that raises `pcClr` it becomes the full option image: bit 8*i+j equals bit j of the byte at 3FF0h+i. It then stays stable while the core runs.
- R6: `run` rises one clock after `pcClr` and stays high while `rstN` and `holdN` stay high.
- R7: A reset sampled low at any point in the window aborts the window. `pinType` is forced to zero, no `pcClr` follows, and the next valid release starts a fresh window from 3FF0h.
- R8: When `holdN` is sampled low while running, `run` falls on that edge and `pinType` keeps its value. While `holdN` stays low, reset pulses do not leave hold: there are no reads, no `pcClr` and `run` stays low. `pinType` is forced to zero only while `rstN` is low.
- R9: Hold is left by raising `holdN` and then applying a valid reset. The release then runs the normal nine-strobe window and `pcClr`.
- R10: `memRd` is never high outside the option window, in particular never while `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cycStb | input | 1 | One-clock instruction-cycle strobe |
| rstN | input | 1 | Active-low external reset |
| holdN | input | 1 | Active-low hold request |
| memData | input | 8 | Byte returned by program memory for `memAddr` |
| memAddr | output | 14 | Program-memory read address |
| memRd | output | 1 | Read enable; byte captured at the next edge |
| pinType | output | 128 | Per-pin output type, 1 = push-pull, 0 = open-drain |
| pcClr | output | 1 | One-clock program-counter clear pulse |
| run | output | 1 | High while the core may execute |

## Verification
Every result is registered.

- `run` and `pcClr` change on the edge that samples the triggering input. `pcClr` rises on the 9th window strobe edge, and `run` rises one edge after that.
- `pinType` is forced to zero as soon as `rstN` goes low. It takes the option image on the same edge as `pcClr`.

The bench drives inputs 1 ns after a rising edge and samples 1 ns after the edge it expects the change on. It records read addresses at the falling edge that comes before each capturing edge. Each window check walks all nine strobes and checks the outputs after every strobe edge and after the edge that follows it.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_WINDOW = 2'd1,
    ST_RUN    = 2'd2,
    ST_HOLD   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take memData into staging, advance pointer
    logic commit;    // copy staging to live output-type register
    logic clearAll;  // clear pointer, staging and live image
    logic forceOd;   // force every pin to open-drain
  } dpCtl_t;

endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int MIN_RST_CYC = 3,
  parameter int OPT_BYTES   = 16
) (
  input  logic   clk,
  input  logic   cycStb,
  input  logic   rstN,
  input  logic   holdN,
  output dpCtl_t ctl,
  output logic   pcClr,
  output logic   run
);

  localparam int FETCH_CYC = OPT_BYTES / 2;
  localparam int WIN_CYC   = FETCH_CYC + 1;
  localparam int CNT_W     = $clog2(MIN_RST_CYC + 1);
  localparam int CYC_W     = $clog2(WIN_CYC);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_RST_CYC);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(WIN_CYC - 1);

  seqState_t state;
  logic [CNT_W-1:0] rstCnt;
  logic [CYC_W-1:0] cyc;
  logic half;
  logic pcClrQ;
  logic lastStb;

  assign lastStb = (state == ST_WINDOW) && rstN && !half && cycStb && (cyc == CYC_LAST);

  always_comb begin
    ctl.capture  = (state == ST_WINDOW) && rstN &&
                   (half || (cycStb && (cyc != CYC_LAST)));
    ctl.commit   = lastStb;
    ctl.clearAll = !rstN && (state != ST_HOLD);
    ctl.forceOd  = !rstN || (state == ST_RESET) || (state == ST_WINDOW);
  end

  always_ff @(posedge clk) begin
    pcClrQ <= 1'b0;
    case (state)
      ST_RESET: begin
        if (!rstN) begin
          if (cycStb && (rstCnt != CNT_MIN)) rstCnt <= rstCnt + CNT_W'(1);
        end else begin
          if (rstCnt == CNT_MIN) begin
            state <= ST_WINDOW;
            cyc   <= '0;
            half  <= 1'b0;
          end
          rstCnt <= '0;
        end
      end
      ST_WINDOW: begin
        if (!rstN) begin
          state  <= ST_RESET;
          rstCnt <= '0;
        end else if (half) begin
          half <= 1'b0;
          cyc  <= cyc + CYC_W'(1);
        end else if (cycStb) begin
          if (cyc == CYC_LAST) begin
            state  <= ST_RUN;
            pcClrQ <= 1'b1;
          end else begin
            half <= 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (!rstN) begin
          state  <= ST_RESET;
          rstCnt <= '0;
        end else if (!holdN) begin
          state <= ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (holdN && !rstN) begin
          state  <= ST_RESET;
          rstCnt <= '0;
        end
      end
      default: begin
        state  <= ST_RESET;
        rstCnt <= '0;
      end
    endcase
  end

  assign pcClr = pcClrQ;
  assign run   = (state == ST_RUN) && !pcClrQ;

endmodule

// File: rtl/boot_dpath.sv
module boot_dpath
  import boot_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OPT_BYTES = 16
) (
  input  logic                   clk,
  input  dpCtl_t                 ctl,
  input  logic [7:0]             memData,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [OPT_BYTES*8-1:0] pinType
);

  localparam int PINS  = OPT_BYTES * 8;
  localparam int PTR_W = $clog2(OPT_BYTES);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'((2 ** ADDR_W) - OPT_BYTES);

  logic [PTR_W-1:0] ptr;
  logic [PINS-1:0]  staging;
  logic [PINS-1:0]  live;

  always_ff @(posedge clk) begin
    if (ctl.clearAll) begin
      ptr     <= '0;
      staging <= '0;
      live    <= '0;
    end else begin
      if (ctl.capture) begin
        staging[{ptr, 3'b000} +: 8] <= memData;
        ptr <= ptr + PTR_W'(1);
      end
      if (ctl.commit) live <= staging;
    end
  end

  assign memAddr = BASE + ADDR_W'(ptr);
  assign pinType = ctl.forceOd ? '0 : live;

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int OPT_BYTES   = 16,
  parameter int MIN_RST_CYC = 3
) (
  input  logic                   clk,
  input  logic                   cycStb,
  input  logic                   rstN,
  input  logic                   holdN,
  input  logic [7:0]             memData,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memRd,
  output logic [OPT_BYTES*8-1:0] pinType,
  output logic                   pcClr,
  output logic                   run
);

  dpCtl_t ctl;

  boot_ctrl #(.MIN_RST_CYC(MIN_RST_CYC), .OPT_BYTES(OPT_BYTES)) u_ctrl (
    .clk(clk), .cycStb(cycStb), .rstN(rstN), .holdN(holdN),
    .ctl(ctl), .pcClr(pcClr), .run(run)
  );

  boot_dpath #(.ADDR_W(ADDR_W), .OPT_BYTES(OPT_BYTES)) u_dpath (
    .clk(clk), .ctl(ctl), .memData(memData),
    .memAddr(memAddr), .pinType(pinType)
  );

  assign memRd = ctl.capture;

endmodule

// File: rtl/boot_chk.sv
module boot_chk #(
  parameter int ADDR_W    = 14,
  parameter int OPT_BYTES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   holdN,
  input logic [ADDR_W-1:0]      memAddr,
  input logic                   memRd,
  input logic [OPT_BYTES*8-1:0] pinType,
  input logic                   pcClr,
  input logic                   run
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !rstN;

  // R1
  od_forced_chk: assert property (@(posedge clk) disable iff (!armed)
    !rstN |-> (pinType == '0));

  // R3
  pc_pulse_chk: assert property (@(posedge clk) disable iff (!armed)
    pcClr |=> !pcClr);

  // R6
  run_after_clr_chk: assert property (@(posedge clk) disable iff (!armed)
    (pcClr && rstN && holdN) |=> run);

  // R6
  run_keep_chk: assert property (@(posedge clk) disable iff (!armed)
    (run && rstN && holdN) |=> run);

  // R8
  hold_stop_chk: assert property (@(posedge clk) disable iff (!armed)
    (run && rstN && !holdN) |=> !run);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!armed)
    (memRd && $past(memRd)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R10
  no_read_run_chk: assert property (@(posedge clk) disable iff (!armed)
    run |-> !memRd);

  // R5
  image_stable_chk: assert property (@(posedge clk) disable iff (!armed)
    (run && rstN && $past(run) && $past(rstN)) |-> $stable(pinType));

endmodule

bind boot_sequencer boot_chk #(.ADDR_W(ADDR_W), .OPT_BYTES(OPT_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .holdN(holdN), .memAddr(memAddr), .memRd(memRd),
  .pinType(pinType), .pcClr(pcClr), .run(run)
);

// File: tb/sim_boot_sequencer.sv
`timescale 1ns/1ps
module sim_boot_sequencer;

  logic clk = 1'b0;
  logic cycStb = 1'b0;
  logic rstN = 1'b0;
  logic holdN = 1'b1;
  logic [7:0] memData;
  logic [13:0] memAddr;
  logic memRd;
  logic [127:0] pinType;
  logic pcClr;
  logic run;

  int nChk = 0;
  int nFail = 0;
  int pcSeen = 0;
  int logCnt = 0;
  logic [13:0] rdLog [32];
  bit done = 0;

  always #2 clk = ~clk;

  boot_sequencer u0 (
    .clk(clk), .cycStb(cycStb), .rstN(rstN), .holdN(holdN),
    .memData(memData), .memAddr(memAddr), .memRd(memRd),
    .pinType(pinType), .pcClr(pcClr), .run(run)
  );

  function automatic logic [7:0] optByte(input logic [3:0] i);
    return 8'hA5 ^ ({4'h0, i} * 8'h1D);
  endfunction

  function automatic logic [127:0] expImg();
    logic [127:0] img;
    for (int i = 0; i < 16; i++) img[i*8 +: 8] = optByte(4'(i));
    return img;
  endfunction

  assign memData = (memAddr >= 14'h3FF0) ? optByte(memAddr[3:0]) : 8'h00;

  always @(negedge clk) begin
    if (memRd) begin
      if (logCnt < 32) rdLog[logCnt] = memAddr;
      logCnt++;
    end
    if (pcClr) pcSeen++;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk); #1;
  endtask

  task automatic instr();
    cycStb = 1'b1; clk1(); cycStb = 1'b0; clk1(); clk1(); clk1();
  endtask

  task automatic doReset(input int n);
    rstN = 1'b0; clk1();
    repeat (n) instr();
    logCnt = 0;
    rstN = 1'b1; clk1();
  endtask

  // walks the nine window strobes right after a release edge
  task automatic runWindow();
    logic [127:0] e;
    e = expImg();
    for (int k = 0; k < 9; k++) begin
      cycStb = 1'b1; clk1(); cycStb = 1'b0;
      if (k < 8) begin
        check(pcClr == 1'b0, "R3", 128'(pcClr), 128'd0);
        check(pinType == '0, "R5", pinType, 128'd0);
      end else begin
        check(pcClr == 1'b1, "R3", 128'(pcClr), 128'd1);
        check(pinType == e, "R5", pinType, e);
        check(run == 1'b0, "R6", 128'(run), 128'd0);
      end
      clk1();
      if (k == 8) begin
        check(pcClr == 1'b0, "R3", 128'(pcClr), 128'd0);
        check(run == 1'b1, "R6", 128'(run), 128'd1);
      end
      clk1(); clk1();
    end
    check(logCnt == 16, "R4", 128'(logCnt), 128'd16);
    for (int i = 0; i < 16; i++)
      check(rdLog[i] == 14'h3FF0 + 14'(i), "R4", 128'(rdLog[i]), 128'(14'h3FF0 + 14'(i)));
  endtask

  localparam int  VEC_N = 6;
  localparam int  VEC_LOW [VEC_N] = '{1, 2, 3, 0, 4, 7};
  localparam bit  VEC_GO  [VEC_N] = '{0, 0, 1, 0, 1, 1};

  initial begin
    int pcBefore;
    logic [127:0] e;
    e = expImg();

    // reset state (R1, R10)
    repeat (3) clk1();
    check(pinType == '0, "R1", pinType, 128'd0);
    check(run == 1'b0, "R1", 128'(run), 128'd0);
    check(pcClr == 1'b0, "R1", 128'(pcClr), 128'd0);
    check(memRd == 1'b0, "R10", 128'(memRd), 128'd0);

    // vector table: reset length versus start (R2, R3, R6)
    for (int v = 0; v < VEC_N; v++) begin
      pcBefore = pcSeen;
      doReset(VEC_LOW[v]);
      repeat (12) instr();
      check((pcSeen - pcBefore) == int'(VEC_GO[v]), "R2", 128'(pcSeen - pcBefore), 128'(VEC_GO[v]));
      check(run == VEC_GO[v], "R2", 128'(run), 128'(VEC_GO[v]));
      check(pinType == (VEC_GO[v] ? e : 128'd0), "R2", pinType, VEC_GO[v] ? e : 128'd0);
      if (!VEC_GO[v]) check(logCnt == 0, "R2", 128'(logCnt), 128'd0);
    end

    // reset while running forces open-drain (R1)
    rstN = 1'b0; clk1();
    check(pinType == '0, "R1", pinType, 128'd0);
    check(run == 1'b0, "R1", 128'(run), 128'd0);

    // exact window timing and read order (R3, R4, R5, R6)
    repeat (3) instr();
    logCnt = 0;
    rstN = 1'b1; clk1();
    runWindow();
    repeat (6) instr();
    check(logCnt == 16, "R10", 128'(logCnt), 128'd16);
    check(run == 1'b1, "R6", 128'(run), 128'd1);

    // abort in the middle of the window (R7)
    doReset(3);
    repeat (4) instr();
    pcBefore = pcSeen;
    rstN = 1'b0; clk1();
    check(pinType == '0, "R7", pinType, 128'd0);
    check(run == 1'b0, "R7", 128'(run), 128'd0);
    repeat (3) instr();
    check(pcSeen == pcBefore, "R7", 128'(pcSeen), 128'(pcBefore));
    logCnt = 0;
    rstN = 1'b1; clk1();
    runWindow();

    // hold entry and reset inside hold (R8)
    holdN = 1'b0; clk1();
    check(run == 1'b0, "R8", 128'(run), 128'd0);
    check(pinType == e, "R8", pinType, e);
    pcBefore = pcSeen;
    rstN = 1'b0; clk1();
    check(pinType == '0, "R8", pinType, 128'd0);
    repeat (4) instr();
    logCnt = 0;
    rstN = 1'b1; clk1();
    repeat (12) instr();
    check(run == 1'b0, "R8", 128'(run), 128'd0);
    check(logCnt == 0, "R8", 128'(logCnt), 128'd0);
    check(pcSeen == pcBefore, "R8", 128'(pcSeen), 128'(pcBefore));
    check(pinType == e, "R8", pinType, e);

    // raising hold alone does not restart (R9)
    holdN = 1'b1; clk1();
    repeat (3) instr();
    check(run == 1'b0, "R9", 128'(run), 128'd0);
    check(pcSeen == pcBefore, "R9", 128'(pcSeen), 128'(pcBefore));

    // full reset after hold raised starts a normal window (R9)
    doReset(3);
    runWindow();
    check(pcSeen == pcBefore + 1, "R9", 128'(pcSeen), 128'(pcBefore + 1));

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule